// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block receives characters from a serial data line whose clock is supplied by a remote master. The block has no bit-rate generator. Both the clock and data lines cross into the system clock domain through two-stage synchronizers. A falling edge of the synchronized serial clock is detected in the system domain, and the data line is sampled on that edge. Bits arrive least significant first and build up 8-bit or 9-bit characters in a shift register. Each completed character moves into a two-entry receive queue that also keeps the ninth bit.

Reception depends only on the continuous-receive enable. While that enable is set, the receiver never idles between characters: every falling serial edge is taken as the next bit. The queue's output is a valid/ready stream. `rd_valid` acts as the receive-complete flag. It stays high while the queue holds an entry, and the oldest entry is held on `rd_data`/`rd_bit9` until a cycle in which both `rd_valid` and `rd_ready` are high. That cycle pops the entry. `rd_ready` has no effect while `rd_valid` is low.

The serial side cannot be stalled. If a character completes while the queue is full and no pop takes place in that cycle, the overrun flag is set and the character is lost. The receiver then stays locked until software clears the continuous-receive enable or the port enable. Clearing the port enable also resets the whole receiver. The interrupt request is a plain combination of registered state, so it stays valid while the core clock is stopped.

Top module: `sync_slave_rx`

## Requirements
- R1: The receiver takes bits only when `port_en`=1, `sync_mode`=1 and `master_sel`=0. With any other setting, serial clock edges capture nothing.
- R2: Data is sampled on falling edges of `ser_clk`, least significant bit first. In 8-bit mode (`wide_en`=0), `rd_data` holds the 8 bits received and `rd_bit9` reads 0.
- R3: In 9-bit mode (`wide_en`=1), the ninth bit received appears on `rd_bit9` and the first eight appear on `rd_data` (bit 0 is the first bit received).
- R4: `rd_valid` rises when a character enters the queue. It stays high while the queue is non-empty, and it falls after the last entry is popped with `rd_valid`&`rd_ready`. It is 0 after reset.
- R5: The queue holds two characters and presents them oldest first.
- R6: If a character completes while the queue is full and no pop happens in that cycle, `overrun` goes to 1 and the character is discarded. While `overrun` is 1, later characters are not received.
- R7: If a character completes in the same cycle that a full queue is popped, the character is stored and `overrun` stays 0.
- R8: `overrun` clears when `cont_en` is cleared, and the queue contents are kept. It also clears when `port_en` is cleared, which also empties the queue and restarts the bit count.
- R9: With `cont_en`=0, serial clock edges are ignored.
- R10: `irq` equals `rd_valid` AND `irq_en`.
- R11: Characters sent back to back, with no idle time between them, are each received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the remote master, idle high |
| ser_dat | input | 1 | Serial data, sampled on falling ser_clk |
| port_en | input | 1 | Port enable; clearing it resets the receiver |
| sync_mode | input | 1 | Synchronous mode select |
| master_sel | input | 1 | Clock-source select; must be 0 for slave operation |
| cont_en | input | 1 | Continuous-receive enable |
| wide_en | input | 1 | 9-bit character enable |
| irq_en | input | 1 | Receive interrupt enable |
| rd_ready | input | 1 | Consumer ready; pops the head entry when rd_valid is high |
| rd_valid | output | 1 | Receive-complete flag, queue non-empty |
| rd_data | output | 8 | Low 8 bits of the oldest character |
| rd_bit9 | output | 1 | Ninth bit of the oldest character |
| overrun | output | 1 | Overrun error, sticky until cleared |
| irq | output | 1 | Receive interrupt request |

## Verification
The corner case is a character completing in the same system cycle that the consumer pops a full queue. The push has to win the freed slot rather than raise an overrun. The bench provokes this by counting the synchronizer and edge-detect registers after the last falling serial edge, and raising `rd_ready` for exactly the cycle in which the completion is taken. It then judges the result by `overrun` staying 0 and by the two remaining entries coming out in order. The same completion without a pop must set `overrun`, and is checked as the contrast case.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef struct packed {
    logic              hi;
    logic [CHAR_W-1:0] lo;
  } rx_char_t;
endpackage

// File: rtl/sync_rx_sync.sv
module sync_rx_sync #(
  parameter int unsigned        WIDTH   = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift
  import sync_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     fall,
  input  logic     dat,
  input  logic     wide,
  output logic     done,
  output rx_char_t word
);
  localparam int unsigned CW = $clog2(CHAR_W + 2);

  logic [CHAR_W:0]  sh, nsh;
  logic [CW-1:0]    bcnt, last;

  assign nsh  = {dat, sh[CHAR_W:1]};
  assign last = wide ? CW'(CHAR_W) : CW'(CHAR_W - 1);
  assign done = !clr && fall && (bcnt == last);

  always_comb begin
    word.hi = wide ? nsh[CHAR_W] : 1'b0;
    word.lo = wide ? nsh[CHAR_W-1:0] : nsh[CHAR_W:1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh   <= '0;
      bcnt <= '0;
    end else if (clr) begin
      bcnt <= '0;
    end else if (fall) begin
      sh   <= nsh;
      bcnt <= done ? '0 : bcnt + 1'b1;
    end

  // R9: a disabled receiver holds no partial character
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bcnt == '0));
endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo
  import sync_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     push,
  input  rx_char_t wdata,
  input  logic     pop,
  output rx_char_t rdata,
  output logic     valid,
  output logic     full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rx_char_t          mem [DEPTH];
  logic [AW-1:0]     rp, wp;
  logic [CW-1:0]     cnt;
  logic              wr, rd;

  assign valid = (cnt != '0);
  assign full  = (cnt == CW'(DEPTH));
  assign rd    = pop && valid;
  assign wr    = push && (!full || rd);
  assign rdata = mem[rp];

  always_ff @(posedge clk)
    if (wr && !flush) mem[wp] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else if (flush) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else begin
      if (wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr, rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end

  // R5: occupancy never exceeds the queue depth
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R4: a lone pop lowers occupancy by one
  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !push && pop && valid) |=> (cnt == $past(cnt) - 1'b1));
  // R7: simultaneous push and pop keep occupancy
  p_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push && pop && valid) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              master_sel,
  input  logic              cont_en,
  input  logic              wide_en,
  input  logic              irq_en,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              overrun,
  output logic              irq
);
  logic     sclk_s, sdat_s, sclk_d, fall;
  logic     rx_en, done, full, pop, flush;
  rx_char_t word, head;

  sync_rx_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ser_clk, ser_dat}), .q({sclk_s, sdat_s}));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_d <= 1'b1;
    else        sclk_d <= sclk_s;

  assign fall  = sclk_d && !sclk_s;
  assign flush = !port_en;
  assign rx_en = port_en && sync_mode && !master_sel && cont_en && !overrun;
  assign pop   = rd_valid && rd_ready;

  sync_rx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .clr(!rx_en), .fall(fall), .dat(sdat_s),
    .wide(wide_en), .done(done), .word(word));

  sync_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(done), .wdata(word),
    .pop(pop), .rdata(head), .valid(rd_valid), .full(full));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    overrun <= 1'b0;
    else if (!port_en || !cont_en) overrun <= 1'b0;
    else if (done && full && !pop) overrun <= 1'b1;

  assign rd_data = head.lo;
  assign rd_bit9 = head.hi;
  assign irq     = rd_valid && irq_en;

  // R6: overrun is sticky while both enables stay set
  p_overrun_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && cont_en && port_en) |=> overrun);
  // R8: clearing either enable clears overrun
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_en || !port_en) |=> !overrun);
  // R8: clearing the port enable empties the queue
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !rd_valid);
  // R6: overrun only rises from a completion into a full, unpopped queue
  p_overrun_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rd_valid && !rd_ready));
endmodule

// File: tb/sim_sync_slave_rx.sv
`timescale 1ns/1ps
module sim_sync_slave_rx;
  localparam int H = 6;

  logic clk = 0, rst_n = 0;
  logic ser_clk = 1, ser_dat = 0;
  logic port_en = 0, sync_mode = 0, master_sel = 0, cont_en = 0;
  logic wide_en = 0, irq_en = 0, rd_ready = 0;
  logic rd_valid, rd_bit9, overrun, irq;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sync_slave_rx u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input int val, input int nb, input bit pop_last);
    @(posedge clk); #1;
    for (int i = 0; i < nb; i++) begin
      ser_dat = val[i];
      repeat (H) @(posedge clk);
      #1 ser_clk = 0;
      if (pop_last && i == nb - 1) begin
        @(posedge clk); @(posedge clk); #1 rd_ready = 1;
        @(posedge clk); #1 rd_ready = 0;
        repeat (H - 3) @(posedge clk);
      end else repeat (H) @(posedge clk);
      #1 ser_clk = 1;
    end
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic pop1();
    @(posedge clk); #1 rd_ready = 1;
    @(posedge clk); #1 rd_ready = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    @(posedge clk); #1;
    chk(!rd_valid && !overrun && !irq, "R4 reset", {rd_valid, overrun, irq}, 0);
    port_en = 1; sync_mode = 1; cont_en = 1; irq_en = 1;

    // R2 / R10: every 8-bit value
    for (int v = 0; v < 256; v++) begin
      send(v, 8, 0);
      chk(rd_valid && rd_data == v[7:0] && !rd_bit9, "R2 byte", {rd_bit9, rd_data}, v);
      chk(irq, "R10 irq", irq, 1);
      pop1(); #1;
      chk(!rd_valid, "R4 empty after pop", rd_valid, 0);
    end

    // R3: 9-bit sweep
    wide_en = 1;
    for (int v = 0; v < 512; v += 3) begin
      send(v, 9, 0);
      chk(rd_valid && {rd_bit9, rd_data} == v[8:0], "R3 nine", {rd_bit9, rd_data}, v);
      pop1();
    end
    wide_en = 0;

    // R5 / R11: back-to-back into queue, oldest first
    send(8'h3c, 8, 0); send(8'hc5, 8, 0);
    chk(rd_data == 8'h3c, "R5 head", rd_data, 8'h3c);
    chk(rd_data == 8'h3c && rd_valid, "R11 first", rd_data, 8'h3c);
    pop1(); #1;
    chk(rd_valid && rd_data == 8'hc5, "R11 second", rd_data, 8'hc5);
    irq_en = 0; #1;
    chk(!irq, "R10 irq masked", irq, 0);
    irq_en = 1;
    pop1(); #1;
    chk(!rd_valid, "R4 drained", rd_valid, 0);

    // R6 / R8: overrun, cleared by cont_en
    send(8'h11, 8, 0); send(8'h22, 8, 0);
    chk(!overrun, "R6 no overrun when just full", overrun, 0);
    send(8'h33, 8, 0);
    chk(overrun, "R6 overrun set", overrun, 1);
    send(8'h44, 8, 0);
    chk(overrun && rd_data == 8'h11, "R6 locked", {overrun, rd_data}, 9'h111);
    @(posedge clk); #1 cont_en = 0;
    repeat (2) @(posedge clk); #1;
    chk(!overrun, "R8 cont_en clears", overrun, 1'b0);
    chk(rd_valid && rd_data == 8'h11, "R8 queue kept", rd_data, 8'h11);
    cont_en = 1;
    pop1(); #1;
    chk(rd_data == 8'h22, "R6 second kept", rd_data, 8'h22);
    pop1(); #1;
    chk(!rd_valid, "R6 discarded chars", rd_valid, 0);

    // R7: completion coincides with pop of a full queue
    send(8'h5a, 8, 0); send(8'ha5, 8, 0);
    send(8'h7e, 8, 1);
    chk(!overrun, "R7 no overrun", overrun, 0);
    chk(rd_data == 8'ha5, "R7 head", rd_data, 8'ha5);
    pop1(); #1;
    chk(rd_valid && rd_data == 8'h7e, "R7 new stored", rd_data, 8'h7e);
    pop1(); #1;

    // R8: port_en clears overrun and queue
    send(8'h01, 8, 0); send(8'h02, 8, 0); send(8'h03, 8, 0);
    chk(overrun, "R8 setup overrun", overrun, 1);
    @(posedge clk); #1 port_en = 0;
    repeat (2) @(posedge clk); #1;
    chk(!overrun && !rd_valid, "R8 port_en reset", {overrun, rd_valid}, 0);
    port_en = 1;

    // R9: cont_en low ignores bits
    cont_en = 0;
    send(8'h99, 8, 0);
    chk(!rd_valid, "R9 ignored", rd_valid, 0);
    cont_en = 1;

    // R1: non-slave settings capture nothing
    master_sel = 1; send(8'h77, 8, 0);
    chk(!rd_valid, "R1 master_sel", rd_valid, 0);
    master_sel = 0; sync_mode = 0; send(8'h66, 8, 0);
    chk(!rd_valid, "R1 sync_mode", rd_valid, 0);
    sync_mode = 1; send(8'hb2, 8, 0);
    chk(rd_valid && rd_data == 8'hb2, "R1 slave ok", rd_data, 8'hb2);
    pop1();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule